// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This unit is the arithmetic core of a multiply-accumulate step in a 16-bit signal-processing datapath. It takes two signed 16-bit sources and forms their fractional product, which is the signed product doubled. It then adds that product to a destination operand, or subtracts it from the destination. The destination is either a full 36-bit accumulator with four guard bits above a 32-bit body, or a single 16-bit word. A word destination is placed in the upper half of the 32-bit body before the operation. Only the upper half of the sum is meant to be written back in that case.

A start strobe launches one operation. One clock later the registered 36-bit result, the 16-bit upper-half word and five condition flags appear, together with a one-cycle valid pulse. The outputs keep their last values until the next strobe. Decoding, register files and memory traffic are handled outside the unit. The unit only sees the operand values, the operation select and the destination-width select.

Top module: `fmac_unit`

## Requirements
- R1: The product term is the signed 16x16 product shifted left by one bit and sign-extended from bit 31 to 36 bits, with no saturation (0x8000 times 0x8000 gives 0xF_8000_0000).
- R2: With sub_i low the result is destination plus product; with sub_i high it is destination minus product, both modulo 2^36.
- R3: With narrow_i high only dst_i[15:0] is used, widened to {four copies of bit 15, the word, sixteen zero bits}; dst_i[35:16] has no effect. word_o always carries result bits 31:16.
- R4: flag_v_o is set exactly when the signed 36-bit addition or subtraction overflows.
- R5: flag_n_o equals bit 35 of the result.
- R6: flag_z_o is set exactly when all 36 result bits are zero.
- R7: flag_e_o is clear exactly when result bits 35 down to 31 are all equal, and set otherwise.
- R8: flag_u_o is set exactly when result bits 31 and 30 are equal.
- R9: Result, word and flags are registered and appear on the first clock edge after start_i is sampled high; valid_o is high for exactly that one cycle per strobe, and back-to-back strobes each produce their own result.
- R10: While start_i is low, result_o, word_o and all flags hold their values whatever the other inputs do.
- R11: A synchronous active-high rst clears result_o, word_o, all flags and valid_o on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one operation this cycle |
| sub_i | input | 1 | 0: add product, 1: subtract product |
| narrow_i | input | 1 | 1: destination is a 16-bit word in dst_i[15:0] |
| src_a_i | input | 16 | First signed source |
| src_b_i | input | 16 | Second signed source |
| dst_i | input | 36 | Destination operand |
| result_o | output | 36 | Registered 36-bit result |
| word_o | output | 16 | Result bits 31:16, the write-back value for a word destination |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_e_o | output | 1 | Guard bits in use |
| flag_u_o | output | 1 | Result unnormalized |
| valid_o | output | 1 | Result valid pulse |

## Verification
The temporal properties assume that rst, start_i and the operand inputs are known at every rising edge. They also assume that inputs change only between edges. The bench meets this by driving every input on the falling edge and holding rst high from time zero. The zero-operand properties expect a zero product to leave a wide destination unchanged and free of overflow. The vector table drives both zero and full-scale operands, as well as destinations at both signed extremes of the 36-bit range, so these properties and the overflow and guard-bit flags are exercised near their boundaries.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic e;
    logic u;
  } fmac_flags_t;

endpackage

// File: rtl/fmac_product.sv
module fmac_product #(
  parameter int SRC_W = 16,
  parameter int ACC_W = 36
) (
  input  logic [SRC_W-1:0] src_a,
  input  logic [SRC_W-1:0] src_b,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int PROD_W = 2 * SRC_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] a_wide;
  logic signed [PROD_W-1:0] b_wide;
  logic signed [PROD_W-1:0] raw;
  logic        [PROD_W-1:0] frac;

  always_comb begin
    a_wide   = {{SRC_W{src_a[SRC_W-1]}}, src_a};
    b_wide   = {{SRC_W{src_b[SRC_W-1]}}, src_b};
    raw      = a_wide * b_wide;
    frac     = raw << 1;
    prod_ext = {{EXT_W{frac[PROD_W-1]}}, frac};
  end
endmodule

// File: rtl/fmac_dest_align.sv
module fmac_dest_align #(
  parameter int SRC_W = 16,
  parameter int ACC_W = 36
) (
  input  logic [ACC_W-1:0] dst,
  input  logic             narrow,
  output logic [ACC_W-1:0] dst_ext
);
  localparam int HI_W = ACC_W - 2 * SRC_W;

  logic [SRC_W-1:0] word;

  always_comb begin
    word = dst[SRC_W-1:0];
    if (narrow) begin
      dst_ext = {{HI_W{word[SRC_W-1]}}, word, {SRC_W{1'b0}}};
    end else begin
      dst_ext = dst;
    end
  end
endmodule

// File: rtl/fmac_addsub.sv
module fmac_addsub #(
  parameter int ACC_W = 36
) (
  input  logic [ACC_W-1:0] dst,
  input  logic [ACC_W-1:0] prod,
  input  logic             sub,
  output logic [ACC_W-1:0] sum,
  output logic             ovf
);
  logic d_msb, p_msb, s_msb;

  always_comb begin
    if (sub) begin
      sum = dst - prod;
    end else begin
      sum = dst + prod;
    end
    d_msb = dst[ACC_W-1];
    p_msb = prod[ACC_W-1];
    s_msb = sum[ACC_W-1];
    if (sub) begin
      ovf = (d_msb != p_msb) && (s_msb != d_msb);
    end else begin
      ovf = (d_msb == p_msb) && (s_msb != d_msb);
    end
  end
endmodule

// File: rtl/fmac_flags.sv
module fmac_flags
  import fmac_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int ACC_W = 36
) (
  input  logic [ACC_W-1:0] sum,
  input  logic             ovf,
  output fmac_flags_t      flags
);
  localparam int BODY_W = 2 * SRC_W;
  localparam int TOP_W  = ACC_W - BODY_W + 1;

  logic [TOP_W-1:0] top;
  logic [TOP_W-2:0] diff;

  assign top = sum[ACC_W-1:BODY_W-1];

  genvar gi;
  generate
    for (gi = 0; gi < TOP_W - 1; gi++) begin : g_diff
      assign diff[gi] = top[gi] ^ top[gi+1];
    end
  endgenerate

  always_comb begin
    flags.n = sum[ACC_W-1];
    flags.z = (sum == '0);
    flags.v = ovf;
    flags.e = |diff;
    flags.u = (sum[BODY_W-1] == sum[BODY_W-2]);
  end
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int SRC_W   = 16,
  parameter int GUARD_W = 4,
  parameter int ACC_W   = 2 * SRC_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic             narrow_i,
  input  logic [SRC_W-1:0] src_a_i,
  input  logic [SRC_W-1:0] src_b_i,
  input  logic [ACC_W-1:0] dst_i,
  output logic [ACC_W-1:0] result_o,
  output logic [SRC_W-1:0] word_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_e_o,
  output logic             flag_u_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] dst_ext;
  logic [ACC_W-1:0] sum;
  logic             ovf;
  fmac_flags_t      flags_nx;
  fmac_flags_t      flags_q;

  fmac_product #(.SRC_W(SRC_W), .ACC_W(ACC_W)) u_product (
    .src_a   (src_a_i),
    .src_b   (src_b_i),
    .prod_ext(prod_ext)
  );

  fmac_dest_align #(.SRC_W(SRC_W), .ACC_W(ACC_W)) u_align (
    .dst    (dst_i),
    .narrow (narrow_i),
    .dst_ext(dst_ext)
  );

  fmac_addsub #(.ACC_W(ACC_W)) u_addsub (
    .dst (dst_ext),
    .prod(prod_ext),
    .sub (sub_i),
    .sum (sum),
    .ovf (ovf)
  );

  fmac_flags #(.SRC_W(SRC_W), .ACC_W(ACC_W)) u_flags (
    .sum  (sum),
    .ovf  (ovf),
    .flags(flags_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      word_o   <= '0;
      flags_q  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        result_o <= sum;
        word_o   <= sum[2*SRC_W-1:SRC_W];
        flags_q  <= flags_nx;
      end
    end
  end

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_e_o = flags_q.e;
  assign flag_u_o = flags_q.u;
endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk #(
  parameter int SRC_W = 16,
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             sub_i,
  input logic             narrow_i,
  input logic [SRC_W-1:0] src_a_i,
  input logic [SRC_W-1:0] src_b_i,
  input logic [ACC_W-1:0] dst_i,
  input logic [ACC_W-1:0] result_o,
  input logic [SRC_W-1:0] word_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o,
  input logic             flag_e_o,
  input logic             flag_u_o,
  input logic             valid_o
);
  localparam int BODY_W = 2 * SRC_W;

  // R9: a strobe yields a valid pulse on the next edge
  a_r9_valid_follows_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o);

  // R9: no strobe, no valid pulse
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !valid_o);

  // R10: outputs hold while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(result_o) && $stable(word_o) && $stable(flag_n_o) &&
                  $stable(flag_z_o) && $stable(flag_v_o) && $stable(flag_e_o) &&
                  $stable(flag_u_o)));

  // R2: a zero product leaves a wide destination unchanged, add or subtract
  a_r2_zero_product: assert property (@(posedge clk) disable iff (rst)
    (start_i && !narrow_i && (src_a_i == '0 || src_b_i == '0) && (sub_i || !sub_i))
      |=> (result_o == $past(dst_i)));

  // R4: a zero product cannot overflow
  a_r4_zero_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (start_i && (src_a_i == '0 || src_b_i == '0)) |=> !flag_v_o);

  // R5: negative flag tracks the result sign
  a_r5_neg: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_n_o == result_o[ACC_W-1]));

  // R6: zero flag tracks the result value
  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_z_o == (result_o == '0)));

  // R7: guard-bit flag
  a_r7_ext: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_e_o == !((&result_o[ACC_W-1:BODY_W-1]) || !(|result_o[ACC_W-1:BODY_W-1]))));

  // R8: unnormalized flag
  a_r8_unnorm: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_u_o == (result_o[BODY_W-1] == result_o[BODY_W-2])));

  // R3: word output is the upper body half
  a_r3_word: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (word_o == result_o[BODY_W-1:SRC_W]));

  // R11: synchronous reset clears everything
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (result_o == '0 && word_o == '0 && !valid_o && !flag_n_o &&
             !flag_z_o && !flag_v_o && !flag_e_o && !flag_u_o));
endmodule

bind fmac_unit fmac_unit_chk #(.SRC_W(SRC_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .sub_i   (sub_i),
  .narrow_i(narrow_i),
  .src_a_i (src_a_i),
  .src_b_i (src_b_i),
  .dst_i   (dst_i),
  .result_o(result_o),
  .word_o  (word_o),
  .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o),
  .flag_v_o(flag_v_o),
  .flag_e_o(flag_e_o),
  .flag_u_o(flag_u_o),
  .valid_o (valid_o)
);

// File: tb/fmac_unit_tb.sv
`timescale 1ns/1ps
module fmac_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic        narrow_i = 1'b0;
  logic [15:0] src_a_i = '0;
  logic [15:0] src_b_i = '0;
  logic [35:0] dst_i = '0;
  logic [35:0] result_o;
  logic [15:0] word_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_e_o, flag_u_o, valid_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fmac_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sub_i(sub_i), .narrow_i(narrow_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .result_o(result_o), .word_o(word_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
    .flag_e_o(flag_e_o), .flag_u_o(flag_u_o), .valid_o(valid_o)
  );

  typedef struct packed {
    logic        sub;
    logic        narrow;
    logic [15:0] a;
    logic [15:0] b;
    logic [35:0] dst;
    logic [35:0] res;
    logic [4:0]  flg;   // {N,Z,V,E,U}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0280, 16'h0200, 36'h0_0000_8000, 36'h0_000A_8000, 5'b00001}, // R1 R2 add
    '{1'b1, 1'b0, 16'h0280, 16'h0200, 36'h0_0000_8000, 36'hF_FFF6_8000, 5'b10001}, // R2 sub, R5
    '{1'b0, 1'b0, 16'h8000, 16'h8000, 36'h0_0000_0000, 36'hF_8000_0000, 5'b10000}, // R1 no saturation
    '{1'b1, 1'b0, 16'h8000, 16'h8000, 36'h0_0000_0000, 36'h0_8000_0000, 5'b00010}, // R7 guard in use
    '{1'b0, 1'b0, 16'h4000, 16'h4000, 36'h0_6000_0000, 36'h0_8000_0000, 5'b00010}, // R7
    '{1'b0, 1'b0, 16'h0001, 16'hFFFF, 36'h0_0000_0002, 36'h0_0000_0000, 5'b01001}, // R6 zero
    '{1'b0, 1'b0, 16'h4000, 16'h4000, 36'h7_FFFF_FFFF, 36'h8_1FFF_FFFF, 5'b10111}, // R4 add ovf
    '{1'b1, 1'b0, 16'h4000, 16'h4000, 36'h8_0000_0000, 36'h7_E000_0000, 5'b00111}, // R4 sub ovf
    '{1'b0, 1'b1, 16'h0100, 16'h0100, 36'h0_0000_1234, 36'h0_1236_0000, 5'b00001}, // R3 word add
    '{1'b1, 1'b1, 16'h0100, 16'h0100, 36'h0_0000_8000, 36'hF_7FFE_0000, 5'b10010}, // R3 word sub, R8 clear
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 36'hA_BCDE_0010, 36'h0_0010_0000, 5'b00001}  // R3 upper dst ignored
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic strobe);
    start_i  = strobe;
    sub_i    = v.sub;
    narrow_i = v.narrow;
    src_a_i  = v.a;
    src_b_i  = v.b;
    dst_i    = v.dst;
  endtask

  task automatic check_out(input string tag, input vec_t v);
    check({tag, " result R2"}, 64'(result_o), 64'(v.res));
    check({tag, " word R3"}, 64'(word_o), 64'(v.res[31:16]));
    check({tag, " flags R4 R5 R6 R7 R8"},
          64'({flag_n_o, flag_z_o, flag_v_o, flag_e_o, flag_u_o}), 64'(v.flg));
    check({tag, " valid R9"}, 64'(valid_o), 64'd1);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset result", 64'(result_o), 64'd0);
    check("R11 reset flags", 64'({flag_n_o, flag_z_o, flag_v_o, flag_e_o, flag_u_o}), 64'd0);
    check("R11 reset valid", 64'(valid_o), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i], 1'b1);
      @(negedge clk);
      start_i = 1'b0;
      check_out($sformatf("vec%0d", i), VECS[i]);
    end

    // R10: idle cycles with changing inputs leave outputs alone
    @(negedge clk);
    drive(VECS[0], 1'b0);
    @(negedge clk);
    drive(VECS[6], 1'b0);
    @(negedge clk);
    check("R10 hold result", 64'(result_o), 64'(VECS[NV-1].res));
    check("R10 hold flags", 64'({flag_n_o, flag_z_o, flag_v_o, flag_e_o, flag_u_o}),
          64'(VECS[NV-1].flg));
    check("R9 idle valid low", 64'(valid_o), 64'd0);

    // R9: back-to-back strobes
    drive(VECS[2], 1'b1);
    @(negedge clk);
    check_out("R9 b2b first", VECS[2]);
    drive(VECS[6], 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    check_out("R9 b2b second", VECS[6]);
    @(negedge clk);
    check("R9 single pulse", 64'(valid_o), 64'd0);

    // R11: reset with a strobe pending clears outputs
    drive(VECS[7], 1'b1);
    rst = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R11 mid reset result", 64'(result_o), 64'd0);
    check("R11 mid reset word", 64'(word_o), 64'd0);
    check("R11 mid reset flags", 64'({flag_n_o, flag_z_o, flag_v_o, flag_e_o, flag_u_o}), 64'd0);
    check("R11 mid reset valid", 64'(valid_o), 64'd0);
    rst = 1'b0;

    // R1: full-scale product after reset release
    @(negedge clk);
    drive(VECS[3], 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    check_out("R1 after reset", VECS[3]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule